// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

A single bank of 32 general-purpose pins behind a small memory-mapped register set. Pad inputs pass through a synchroniser before any logic sees them. The bank holds an output latch and a per-pin direction that drive the pad output and the pad output enable. A read of the value register returns the synchronised pad level, even for pins being driven as outputs. Software that needs what it last wrote reads the latch read-back register instead.

Each pin can post an interrupt. Three type registers select edge or level mode, the polarity, and whether both edges count. An event latches into a sticky status bit only while the pin's enable bit is set. Writing ones to the status register clears those bits. One combined interrupt line reports whether any status bit is set. Reads are combinational on the address bus. Writes take effect on the clock edge that samples `wr_en`.

Register byte offsets: value 0x00, direction 0x04, latch read-back 0x08, interrupt enable 0x10, type-0 0x14, type-1 0x18, type-2 0x1C, status 0x20.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset, every register reads 0, `pad_oe` and `pad_out` are 0 and `irq` is 0.
- R2: A read of offset 0x00 returns the pad input two clock edges after the pad changes, whatever the pin's direction.
- R3: A write to offset 0x00 loads the output latch, which drives `pad_out` from the next cycle and reads back at offset 0x08. Writes to 0x08 are ignored.
- R4: A write to offset 0x04 sets the direction, where bit value 1 means the pin drives (`pad_oe` high) and 0 means input.
- R5: With type-1=0, type-2=0 and type-0=1 for a pin, a low-to-high transition sets its status and a high-to-low transition does not.
- R6: With type-1=0, type-2=0 and type-0=0, a high-to-low transition sets status and a low-to-high transition does not.
- R7: With type-1=0 and type-2=1, either transition sets status.
- R8: With type-1=1, a high level (type-0=1) or a low level (type-0=0) sets status, and the opposite level does not.
- R9: A status bit never becomes set while the pin's enable bit (offset 0x10) is 0.
- R10: Writing offset 0x20 clears each status bit written as 1 and leaves bits written as 0. A clear takes priority over a new event in the same cycle, so an active level sets the bit again one cycle later.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: A pad transition that qualifies as an event shows in status three clock edges after the pad changes (two synchroniser stages plus the status register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output latch driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | OR of all status bits |

## Verification
Register writes are visible at the first falling clock edge after the capturing rising edge. The value register follows a pad change after two rising edges, and status follows after three. The bench drives every input on a falling edge and samples on later falling edges, so each latency check can read the old value one edge before the new value is due. The level re-arm check reads status 0 straight after a clear and 1 one edge later, which pins down the clear-over-set priority.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFF_VALUE = 6'h00;
    localparam logic [REG_AW-1:0] OFF_DIR   = 6'h04;
    localparam logic [REG_AW-1:0] OFF_LATCH = 6'h08;
    localparam logic [REG_AW-1:0] OFF_IEN   = 6'h10;
    localparam logic [REG_AW-1:0] OFF_T0    = 6'h14;
    localparam logic [REG_AW-1:0] OFF_T1    = 6'h18;
    localparam logic [REG_AW-1:0] OFF_T2    = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_STAT  = 6'h20;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VALUE,
        SEL_DIR,
        SEL_LATCH,
        SEL_IEN,
        SEL_T0,
        SEL_T1,
        SEL_T2,
        SEL_STAT
    } reg_sel_e;

    // Per-pin trigger selection, taken from type-2, type-1 and type-0
    typedef struct packed {
        logic both;   // edge mode: any transition
        logic level;  // 1 = level sensitive
        logic high;   // polarity: rising / high when set
    } trig_t;

    function automatic reg_sel_e decode_reg(input logic [REG_AW-1:0] a);
        case (a)
            OFF_VALUE: return SEL_VALUE;
            OFF_DIR:   return SEL_DIR;
            OFF_LATCH: return SEL_LATCH;
            OFF_IEN:   return SEL_IEN;
            OFF_T0:    return SEL_T0;
            OFF_T1:    return SEL_T1;
            OFF_T2:    return SEL_T2;
            OFF_STAT:  return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic pin_event(input trig_t t, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (t.level)
            return t.high ? cur : ~cur;
        else if (t.both)
            return rise | fall;
        else
            return t.high ? rise : fall;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] t0,
    input  logic [W-1:0] t1,
    input  logic [W-1:0] t2,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] prev_q;
    logic [W-1:0] evt;
    logic [W-1:0] clr_bits;

    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_t trig;
        assign trig   = '{both: t2[i], level: t1[i], high: t0[i]};
        assign evt[i] = pin_event(trig, cur[i], prev_q[i]);
    end

    assign clr_bits = clr_stb ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            status <= '0;
        end else begin
            prev_q <= cur;
            status <= (status | (evt & ien)) & ~clr_bits;
        end
    end

    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & ~$past(ien)) == '0);

    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_stb) |-> ((status & $past(clr_mask)) == '0));

    // R5
    edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & ~$past(t1) & ~($past(cur) ^ $past(prev_q))) == '0);

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      sync_val,
    input  logic [W-1:0]      status,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      latch,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      ien,
    output logic [W-1:0]      t0,
    output logic [W-1:0]      t1,
    output logic [W-1:0]      t2,
    output logic              clr_stb,
    output logic [W-1:0]      clr_mask
);
    reg_sel_e sel;
    assign sel = decode_reg(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            dir   <= '0;
            ien   <= '0;
            t0    <= '0;
            t1    <= '0;
            t2    <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_VALUE: latch <= wr_data;
                SEL_DIR:   dir   <= wr_data;
                SEL_IEN:   ien   <= wr_data;
                SEL_T0:    t0    <= wr_data;
                SEL_T1:    t1    <= wr_data;
                SEL_T2:    t2    <= wr_data;
                default:   ;
            endcase
        end
    end

    assign clr_stb  = wr_en && (sel == SEL_STAT);
    assign clr_mask = wr_data;

    always_comb begin
        case (sel)
            SEL_VALUE: rd_data = sync_val;
            SEL_DIR:   rd_data = dir;
            SEL_LATCH: rd_data = latch;
            SEL_IEN:   rd_data = ien;
            SEL_T0:    rd_data = t0;
            SEL_T1:    rd_data = t1;
            SEL_T2:    rd_data = t2;
            SEL_STAT:  rd_data = status;
            default:   rd_data = '0;
        endcase
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(addr) == OFF_VALUE) |-> latch == $past(wr_data));

    // R4
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(addr) == OFF_DIR) |-> dir == $past(wr_data));

    // R3
    latch_ro_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(addr) == OFF_LATCH) |-> $stable(latch));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              irq
);
    logic [W-1:0] sync_val;
    logic [W-1:0] status;
    logic [W-1:0] latch;
    logic [W-1:0] dir;
    logic [W-1:0] ien;
    logic [W-1:0] t0;
    logic [W-1:0] t1;
    logic [W-1:0] t2;
    logic         clr_stb;
    logic [W-1:0] clr_mask;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_val)
    );

    gpio_reg_file #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .sync_val (sync_val),
        .status   (status),
        .rd_data  (rd_data),
        .latch    (latch),
        .dir      (dir),
        .ien      (ien),
        .t0       (t0),
        .t1       (t1),
        .t2       (t2),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask)
    );

    gpio_irq_unit #(.W(W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_val),
        .ien      (ien),
        .t0       (t0),
        .t1       (t1),
        .t2       (t2),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .status   (status)
    );

    assign pad_out = latch;
    assign pad_oe  = dir;
    assign irq     = |status;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq && pad_oe == '0 && pad_out == '0));

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] v;

    always #4 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {type2, type1, type0, pad start, pad end, expected status}
    localparam logic [5:0] VEC [0:9] = '{
        6'b001_01_1, 6'b001_10_0, 6'b000_10_1, 6'b000_01_0, 6'b100_01_1,
        6'b100_10_1, 6'b011_01_1, 6'b010_10_1, 6'b011_00_0, 6'b010_11_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(OFF_VALUE, v); check("R1 value", v, 0);
        rd(OFF_DIR, v);   check("R1 dir", v, 0);
        rd(OFF_LATCH, v); check("R1 latch", v, 0);
        rd(OFF_IEN, v);   check("R1 ien", v, 0);
        rd(OFF_T0, v);    check("R1 t0", v, 0);
        rd(OFF_T1, v);    check("R1 t1", v, 0);
        rd(OFF_T2, v);    check("R1 t2", v, 0);
        rd(OFF_STAT, v);  check("R1 stat", v, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R4: direction drives pad_oe
        wr(OFF_DIR, 32'h0000_00F0);
        check("R4 pad_oe", pad_oe, 32'h0000_00F0);

        // R3: latch, read-back, read-only read-back; R2 value shows pad
        wr(OFF_VALUE, 32'h0000_00A5);
        check("R3 pad_out", pad_out, 32'h0000_00A5);
        rd(OFF_LATCH, v); check("R3 readback", v, 32'h0000_00A5);
        rd(OFF_VALUE, v); check("R2 value is pad not latch", v, 0);
        wr(OFF_LATCH, 32'hFFFF_FFFF);
        rd(OFF_LATCH, v); check("R3 readback write ignored", v, 32'h0000_00A5);
        check("R3 pad_out after ignored write", pad_out, 32'h0000_00A5);

        // R2: two-edge latency on the value register
        pad_in = 32'h1234_0000;
        @(negedge clk); rd(OFF_VALUE, v); check("R2 value after 1 edge", v, 0);
        @(negedge clk); rd(OFF_VALUE, v); check("R2 value after 2 edges", v, 32'h1234_0000);

        // R12 / R5: rising edge on pin 8, three-edge latency
        wr(OFF_T0, 32'h0000_0100);
        wr(OFF_IEN, 32'h0000_0100);
        wr(OFF_STAT, 32'hFFFF_FFFF);
        pad_in[8] = 1'b1;
        idle(2); rd(OFF_STAT, v); check("R12 status after 2 edges", v, 0);
        idle(1); rd(OFF_STAT, v); check("R12 status after 3 edges", v, 32'h0000_0100);
        check("R11 irq with status set", {31'b0, irq}, 1);

        // R10: zeros leave, ones clear
        wr(OFF_STAT, 32'h0000_0000);
        rd(OFF_STAT, v); check("R10 zero write keeps", v, 32'h0000_0100);
        wr(OFF_STAT, 32'h0000_0100);
        rd(OFF_STAT, v); check("R10 one clears", v, 0);
        check("R11 irq low after clear", {31'b0, irq}, 0);

        // R10 / R8: active high level re-arms one cycle after clear
        wr(OFF_T1, 32'h0000_0100);
        idle(1);
        rd(OFF_STAT, v); check("R8 level high sets", v, 32'h0000_0100);
        wr(OFF_STAT, 32'h0000_0100);
        rd(OFF_STAT, v); check("R10 clear wins over level", v, 0);
        idle(1);
        rd(OFF_STAT, v); check("R10 level re-sets next cycle", v, 32'h0000_0100);

        // R9: disabled pin ignores active level
        wr(OFF_IEN, 32'h0);
        wr(OFF_STAT, 32'hFFFF_FFFF);
        idle(3);
        rd(OFF_STAT, v); check("R9 disabled pin stays clear", v, 0);
        check("R9 irq low", {31'b0, irq}, 0);

        // R11: two pins, combined output
        wr(OFF_T1, 32'h0000_0300);
        wr(OFF_IEN, 32'h0000_0300);
        idle(2);
        rd(OFF_STAT, v); check("R8 high and low levels", v, 32'h0000_0300);
        pad_in[8] = 1'b0; pad_in[9] = 1'b1;
        idle(4);
        wr(OFF_STAT, 32'h0000_0100);
        rd(OFF_STAT, v); check("R11 one pin left", v, 32'h0000_0200);
        check("R11 irq with one bit", {31'b0, irq}, 1);
        wr(OFF_STAT, 32'h0000_0200);
        check("R11 irq after all cleared", {31'b0, irq}, 0);

        // Table walk: R5 R6 R7 R8 per trigger mode
        wr(OFF_IEN, 32'h0);
        pad_in = '0;
        idle(4);
        wr(OFF_STAT, 32'hFFFF_FFFF);
        for (int k = 0; k < 10; k++) begin
            int pin;
            logic [31:0] bit_m;
            pin = k + 10;
            bit_m = 32'h1 << pin;
            wr(OFF_IEN, 32'h0);
            wr(OFF_T2, VEC[k][5] ? bit_m : 32'h0);
            wr(OFF_T1, VEC[k][4] ? bit_m : 32'h0);
            wr(OFF_T0, VEC[k][3] ? bit_m : 32'h0);
            pad_in[pin] = VEC[k][2];
            idle(4);
            wr(OFF_STAT, 32'hFFFF_FFFF);
            wr(OFF_IEN, bit_m);
            pad_in[pin] = VEC[k][1];
            idle(4);
            rd(OFF_STAT, v);
            check($sformatf("R5 R6 R7 R8 mode entry %0d status", k), v, VEC[k][0] ? bit_m : 32'h0);
            check($sformatf("R11 mode entry %0d irq", k), {31'b0, irq}, {31'b0, VEC[k][0]});
        end

        finish_run();
    end
endmodule